// File: doc/BRIEF.md
# USB Function Token Handshake Responder

This block sits behind the receive path of a USB function. The packet decoder hands it one token at a time: the PID byte, the 7-bit address, the 4-bit endpoint field, the received byte count and a CRC-good flag. The responder checks the token against the device address and against up to four configured endpoints. It then decides how the function answers. For an IN token it either asks the transmit side to start the data phase or asks for a handshake. For OUT and SETUP it waits for the data stage to finish and then asks for the handshake that goes back to the host. PID generation on the wire, CRC computation and serialisation are done outside this block.

Each endpoint has an enable bit, a 4-bit endpoint number, a two-bit transfer type and two two-bit response overrides: one for received data and one for transmit requests. The override selects normal behaviour, silence, forced NAK or forced STALL. The control flow is a three-state machine:

- **ST_IDLE** takes a new token.
- **ST_DATA** waits for the end of an OUT or SETUP data stage.
- **ST_RESP** drives the chosen request for exactly one cycle.

The transitions are:

- **accept_in**: ST_IDLE to ST_RESP, when an IN token gets an answer.
- **accept_rx**: ST_IDLE to ST_DATA, when an OUT or SETUP token is accepted.
- **data_end**: ST_DATA to ST_RESP, when the data stage ends and a handshake is due.
- **data_quiet**: ST_DATA to ST_IDLE, when the data stage ends and no handshake is due.
- **abandon**: ST_DATA to ST_IDLE, when a new token arrives during the wait.
- **resp_done**: ST_RESP to ST_IDLE, after the one-cycle request.

Top module: `usb_tok_resp`

## Requirements
- R1: A token is dropped with no request of any kind when any of these holds: its PID byte fails the check (upper nibble not the bitwise complement of the lower nibble), its CRC-good flag is low, its byte count is not 3, or its PID is not OUT (0xE1), IN (0x69) or SETUP (0x2D).
- R2: A token is answered only when its 7-bit address equals the device address input. The bench runs with the reset value 0x00 and then with a programmed address.
- R3: The target endpoint is the lowest-index enabled endpoint whose number equals the token's endpoint field. A token that matches no enabled endpoint gets no response.
- R4: A SETUP token is accepted only by an endpoint whose type is control. The type encoding is 00 control, 01 interrupt, 10 bulk, 11 isochronous. On any other type, SETUP is dropped and no handshake follows its data.
- R5: After OUT data, a corrupted data stage gets no handshake. Otherwise the receive override decides: 00 gives ACK (hs_pid 0xD2), 01 gives nothing, 10 gives NAK (0x5A), 11 gives STALL (0x1E).
- R6: For IN, the transmit override decides. 00 starts the data phase (tx_start, with tx_ep giving the endpoint index) when that endpoint's fifo_ready bit is set, and gives NAK when it is clear. 01 gives nothing, 10 gives NAK, 11 gives STALL.
- R7: SETUP data received without error is always answered with ACK, whatever the receive override. SETUP data with an error gets no handshake.
- R8: An isochronous endpoint never produces a handshake, whether or not the data had an error. IN on such an endpoint starts the data phase only when its transmit override is 00 and its FIFO is ready; otherwise nothing is produced.
- R9: On a control endpoint, override values 10 and 11 are treated as 00, in both directions.
- R10: An IN response is a single-cycle pulse in the cycle after the token is sampled. An OUT or SETUP handshake is a single-cycle pulse in the cycle after data_done is sampled. A token that arrives while data is still awaited cancels the pending handshake and is not itself evaluated.
- R11: During and right after reset, hs_req and tx_start are low. hs_pid and tx_ep read zero whenever their request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | One-cycle strobe: a decoded token is present |
| tok_pid | input | 8 | Raw PID byte of the token |
| tok_len | input | 4 | Number of bytes received in the token packet |
| tok_crc_ok | input | 1 | Token CRC checked good |
| tok_addr | input | 7 | Token address field |
| tok_ep | input | 4 | Token endpoint field |
| dev_addr | input | 7 | Device address register |
| ep_en | input | 4 | Per-endpoint enable |
| ep_num | input | 16 | Per-endpoint number, 4 bits each |
| ep_mode | input | 8 | Per-endpoint transfer type, 2 bits each |
| ep_rhs | input | 8 | Per-endpoint receive response override, 2 bits each |
| ep_ths | input | 8 | Per-endpoint transmit response override, 2 bits each |
| fifo_ready | input | 4 | Per-endpoint transmit FIFO holds data |
| data_done | input | 1 | One-cycle strobe: OUT/SETUP data stage ended |
| data_err | input | 1 | The data stage that just ended was corrupted |
| hs_req | output | 1 | Send a handshake now |
| hs_pid | output | 8 | Handshake PID byte (0xD2, 0x5A or 0x1E) |
| tx_start | output | 1 | Start the IN data phase now |
| tx_ep | output | 2 | Endpoint index for the data phase |

## Verification
The bench builds the block with its default parameters: four endpoints, 4-bit endpoint numbers and a 7-bit address. With four slots it can give each of the four transfer types its own endpoint and set each one to a different override pair, so a single fixed configuration covers every row of the response tables. That configuration includes a control endpoint set to the forbidden override values. The 4-bit number field also makes room for an unmatched endpoint number, and a later directed test maps two endpoints to the same number to expose the lowest-index priority.

// File: rtl/usb_tok_resp_pkg.sv
package usb_tok_resp_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_RESP} st_t;
    typedef enum logic [2:0] {RS_NONE, RS_ACK, RS_NAK, RS_STALL, RS_DATA} rsp_t;
    typedef enum logic [1:0] {TK_NONE, TK_OUT, TK_IN, TK_SETUP} tok_t;

    localparam logic [3:0] PID_OUT   = 4'h1;
    localparam logic [3:0] PID_IN    = 4'h9;
    localparam logic [3:0] PID_SETUP = 4'hD;

    localparam logic [1:0] MODE_CTRL = 2'b00;
    localparam logic [1:0] MODE_ISO  = 2'b11;

    localparam logic [1:0] HS_NORMAL = 2'b00;
    localparam logic [1:0] HS_QUIET  = 2'b01;
    localparam logic [1:0] HS_NAK    = 2'b10;
    localparam logic [1:0] HS_STALL  = 2'b11;

    // control endpoints may not be forced to NAK or STALL
    function automatic logic [1:0] eff_ovr(input logic [1:0] mode, input logic [1:0] ovr);
        return (mode == MODE_CTRL && ovr[1]) ? HS_NORMAL : ovr;
    endfunction

    function automatic rsp_t rx_answer(input logic [1:0] mode, input logic [1:0] rhs,
                                       input logic err, input logic setup);
        rsp_t r;
        if (err || mode == MODE_ISO) r = RS_NONE;
        else if (setup)              r = RS_ACK;
        else begin
            unique case (eff_ovr(mode, rhs))
                HS_NORMAL: r = RS_ACK;
                HS_QUIET:  r = RS_NONE;
                HS_NAK:    r = RS_NAK;
                default:   r = RS_STALL;
            endcase
        end
        return r;
    endfunction

    function automatic rsp_t tx_answer(input logic [1:0] mode, input logic [1:0] ths,
                                       input logic ready);
        rsp_t r;
        if (mode == MODE_ISO) r = (ths == HS_NORMAL && ready) ? RS_DATA : RS_NONE;
        else begin
            unique case (eff_ovr(mode, ths))
                HS_NORMAL: r = ready ? RS_DATA : RS_NAK;
                HS_QUIET:  r = RS_NONE;
                HS_NAK:    r = RS_NAK;
                default:   r = RS_STALL;
            endcase
        end
        return r;
    endfunction

    function automatic logic [7:0] hs_byte(input rsp_t r);
        logic [7:0] b;
        unique case (r)
            RS_ACK:   b = 8'hD2;
            RS_NAK:   b = 8'h5A;
            RS_STALL: b = 8'h1E;
            default:  b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/usb_tok_check.sv
module usb_tok_check
    import usb_tok_resp_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int LEN_W  = 4
) (
    input  logic [7:0]        pid,
    input  logic [LEN_W-1:0]  len,
    input  logic              crc_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] dev_addr,
    output tok_t              kind
);
    localparam logic [LEN_W-1:0] TOK_BYTES = LEN_W'(3);

    logic frame_ok;
    assign frame_ok = (pid[7:4] == ~pid[3:0]) && crc_ok && (len == TOK_BYTES)
                      && (addr == dev_addr);

    always_comb begin
        kind = TK_NONE;
        if (frame_ok) begin
            if      (pid[3:0] == PID_OUT)   kind = TK_OUT;
            else if (pid[3:0] == PID_IN)    kind = TK_IN;
            else if (pid[3:0] == PID_SETUP) kind = TK_SETUP;
        end
    end

    // R1: any accepted token carries a good CRC and three bytes
    always_comb begin
        if (kind != TK_NONE) begin
            p_tok_frame_r1: assert (crc_ok && len == TOK_BYTES);
        end
    end
endmodule

// File: rtl/usb_ep_sel.sv
module usb_ep_sel #(
    parameter int NUM_EP = 4,
    parameter int EPN_W  = 4,
    localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic [NUM_EP-1:0]       en,
    input  logic [NUM_EP*EPN_W-1:0] num,
    input  logic [EPN_W-1:0]        tok_ep,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [NUM_EP-1:0] match;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_match
        assign match[g] = en[g] && (num[g*EPN_W +: EPN_W] == tok_ep);
    end

    // lowest index wins
    always_comb begin
        idx = '0;
        for (int i = NUM_EP - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
    assign hit = |match;
endmodule

// File: rtl/usb_tok_resp.sv
module usb_tok_resp
    import usb_tok_resp_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPN_W  = 4,
    parameter int ADDR_W = 7,
    parameter int LEN_W  = 4,
    localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tok_valid,
    input  logic [7:0]              tok_pid,
    input  logic [LEN_W-1:0]        tok_len,
    input  logic                    tok_crc_ok,
    input  logic [ADDR_W-1:0]       tok_addr,
    input  logic [EPN_W-1:0]        tok_ep,
    input  logic [ADDR_W-1:0]       dev_addr,
    input  logic [NUM_EP-1:0]       ep_en,
    input  logic [NUM_EP*EPN_W-1:0] ep_num,
    input  logic [NUM_EP*2-1:0]     ep_mode,
    input  logic [NUM_EP*2-1:0]     ep_rhs,
    input  logic [NUM_EP*2-1:0]     ep_ths,
    input  logic [NUM_EP-1:0]       fifo_ready,
    input  logic                    data_done,
    input  logic                    data_err,
    output logic                    hs_req,
    output logic [7:0]              hs_pid,
    output logic                    tx_start,
    output logic [IDX_W-1:0]        tx_ep
);
    tok_t             kind;
    logic             hit;
    logic [IDX_W-1:0] sel;

    usb_tok_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
        .pid(tok_pid), .len(tok_len), .crc_ok(tok_crc_ok),
        .addr(tok_addr), .dev_addr(dev_addr), .kind(kind)
    );

    usb_ep_sel #(.NUM_EP(NUM_EP), .EPN_W(EPN_W)) sel_i (
        .en(ep_en), .num(ep_num), .tok_ep(tok_ep), .hit(hit), .idx(sel)
    );

    st_t              st, st_n;
    rsp_t             rsp_q, rsp_n;
    logic [IDX_W-1:0] ep_q, ep_n;
    logic             setup_q, setup_n;

    logic [1:0] new_mode, held_mode;
    assign new_mode  = ep_mode[sel*2 +: 2];
    assign held_mode = ep_mode[ep_q*2 +: 2];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            rsp_q   <= RS_NONE;
            ep_q    <= '0;
            setup_q <= 1'b0;
        end else begin
            st      <= st_n;
            rsp_q   <= rsp_n;
            ep_q    <= ep_n;
            setup_q <= setup_n;
        end
    end

    // next state
    always_comb begin
        st_n    = st;
        rsp_n   = rsp_q;
        ep_n    = ep_q;
        setup_n = setup_q;
        unique case (st)
            ST_IDLE: begin
                if (tok_valid && hit && kind != TK_NONE) begin
                    if (kind == TK_IN) begin
                        rsp_n = tx_answer(new_mode, ep_ths[sel*2 +: 2], fifo_ready[sel]);
                        ep_n  = sel;
                        st_n  = (rsp_n != RS_NONE) ? ST_RESP : ST_IDLE;       // accept_in
                    end else if (kind == TK_OUT || new_mode == MODE_CTRL) begin
                        ep_n    = sel;
                        setup_n = (kind == TK_SETUP);
                        st_n    = ST_DATA;                                    // accept_rx
                    end
                end
            end
            ST_DATA: begin
                if (tok_valid) begin
                    st_n = ST_IDLE;                                           // abandon
                end else if (data_done) begin
                    rsp_n = rx_answer(held_mode, ep_rhs[ep_q*2 +: 2], data_err, setup_q);
                    st_n  = (rsp_n != RS_NONE) ? ST_RESP : ST_IDLE;           // data_end / data_quiet
                end
            end
            ST_RESP: st_n = ST_IDLE;                                          // resp_done
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hs_req   = (st == ST_RESP) && (rsp_q inside {RS_ACK, RS_NAK, RS_STALL});
        tx_start = (st == ST_RESP) && (rsp_q == RS_DATA);
        hs_pid   = hs_req ? hs_byte(rsp_q) : 8'h00;
        tx_ep    = tx_start ? ep_q : '0;
    end

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_req && tx_start));
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req || tx_start) |=> !(hs_req || tx_start));
    p_bad_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && tok_valid && tok_len != LEN_W'(3)) |=> !(hs_req || tx_start));
    p_setup_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && setup_q && data_done && !data_err && !tok_valid)
        |=> (hs_req && hs_pid == 8'hD2));
    p_iso_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req |-> (held_mode != MODE_ISO));
    p_pid_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req |-> (hs_pid == 8'hD2 || hs_pid == 8'h5A || hs_pid == 8'h1E));
endmodule

// File: tb/usb_tok_resp_tb_top.sv
module usb_tok_resp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic [7:0]  tok_pid = 8'h00;
    logic [3:0]  tok_len = 4'd3;
    logic        tok_crc_ok = 1'b1;
    logic [6:0]  tok_addr = 7'h00;
    logic [3:0]  tok_ep = 4'd0;
    logic [6:0]  dev_addr = 7'h00;
    logic [3:0]  ep_en = 4'b1111;
    logic [15:0] ep_num  = {4'd7, 4'd5, 4'd2, 4'd0};
    logic [7:0]  ep_mode = {2'b11, 2'b01, 2'b10, 2'b00};
    logic [7:0]  ep_rhs  = {2'b00, 2'b01, 2'b10, 2'b11};
    logic [7:0]  ep_ths  = {2'b00, 2'b01, 2'b11, 2'b10};
    logic [3:0]  fifo_ready = 4'b0000;
    logic        data_done = 1'b0;
    logic        data_err = 1'b0;
    logic        hs_req;
    logic [7:0]  hs_pid;
    logic        tx_start;
    logic [1:0]  tx_ep;

    always #5 clk = ~clk;

    usb_tok_resp dut_i (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid),
        .tok_len(tok_len), .tok_crc_ok(tok_crc_ok), .tok_addr(tok_addr),
        .tok_ep(tok_ep), .dev_addr(dev_addr), .ep_en(ep_en), .ep_num(ep_num),
        .ep_mode(ep_mode), .ep_rhs(ep_rhs), .ep_ths(ep_ths),
        .fifo_ready(fifo_ready), .data_done(data_done), .data_err(data_err),
        .hs_req(hs_req), .hs_pid(hs_pid), .tx_start(tx_start), .tx_ep(tx_ep)
    );

    int checks = 0;
    int failures = 0;
    int n_hs, n_tx;
    logic [7:0] last_pid;
    logic [1:0] last_ep;

    localparam logic [7:0] T_OUT = 8'hE1, T_IN = 8'h69, T_SETUP = 8'h2D;

    // {kind[13:12] 1=OUT 2=IN 3=SETUP, ep[11:8], err[7], fifo[6], exp[5:3] 0 none 1 ACK 2 NAK 3 STALL 4 DATA, idx[2:1], pad[0]}
    localparam logic [13:0] VEC [16] = '{
        {2'd1, 4'd0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0},
        {2'd2, 4'd0, 1'b0, 1'b1, 3'd4, 2'd0, 1'b0},
        {2'd2, 4'd0, 1'b0, 1'b0, 3'd2, 2'd0, 1'b0},
        {2'd3, 4'd0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0},
        {2'd3, 4'd0, 1'b1, 1'b0, 3'd0, 2'd0, 1'b0},
        {2'd1, 4'd2, 1'b0, 1'b0, 3'd2, 2'd1, 1'b0},
        {2'd2, 4'd2, 1'b0, 1'b1, 3'd3, 2'd1, 1'b0},
        {2'd1, 4'd5, 1'b0, 1'b0, 3'd0, 2'd2, 1'b0},
        {2'd2, 4'd5, 1'b0, 1'b1, 3'd0, 2'd2, 1'b0},
        {2'd1, 4'd7, 1'b0, 1'b0, 3'd0, 2'd3, 1'b0},
        {2'd1, 4'd7, 1'b1, 1'b0, 3'd0, 2'd3, 1'b0},
        {2'd2, 4'd7, 1'b0, 1'b1, 3'd4, 2'd3, 1'b0},
        {2'd2, 4'd7, 1'b0, 1'b0, 3'd0, 2'd3, 1'b0},
        {2'd3, 4'd2, 1'b0, 1'b0, 3'd0, 2'd1, 1'b0},
        {2'd1, 4'd2, 1'b1, 1'b0, 3'd0, 2'd1, 1'b0},
        {2'd2, 4'd9, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0}
    };

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic sample();
        if (hs_req) begin n_hs++; last_pid = hs_pid; end
        if (tx_start) begin n_tx++; last_ep = tx_ep; end
    endtask

    // drives one token, optionally followed by a data stage, and records the outputs
    task automatic txn(input logic [7:0] pid, input logic [3:0] ep, input logic [6:0] addr,
                       input logic [3:0] len, input logic crc, input logic dd, input logic err);
        n_hs = 0; n_tx = 0; last_pid = 8'h00; last_ep = 2'd0;
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = pid; tok_ep = ep; tok_addr = addr;
        tok_len = len; tok_crc_ok = crc;
        @(negedge clk);
        tok_valid = 1'b0; tok_len = 4'd3; tok_crc_ok = 1'b1;
        sample();
        if (dd) begin
            data_done = 1'b1; data_err = err;
            @(negedge clk);
            data_done = 1'b0; data_err = 1'b0;
            sample();
        end
        repeat (2) begin @(negedge clk); sample(); end
    endtask

    task automatic expect_rsp(input int exp, input logic [1:0] idx, input string req);
        logic ok;
        int act;
        act = (n_tx != 0) ? 4 : (n_hs == 0) ? 0 :
              (last_pid == 8'hD2) ? 1 : (last_pid == 8'h5A) ? 2 : (last_pid == 8'h1E) ? 3 : 7;
        ok = (n_hs + n_tx <= 1) && (act == exp) && (exp != 4 || last_ep == idx);
        check(ok, req, "response code", act, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!hs_req && !tx_start && hs_pid == 8'h00, "R11", "outputs in reset",
              {hs_req, tx_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!hs_req && !tx_start && tx_ep == 2'd0, "R11", "outputs after reset",
              {hs_req, tx_start}, 0);

        // table walk
        for (int i = 0; i < 16; i++) begin
            logic [13:0] v;
            logic [7:0] p;
            string rq;
            v = VEC[i];
            p = (v[13:12] == 2'd1) ? T_OUT : (v[13:12] == 2'd2) ? T_IN : T_SETUP;
            fifo_ready = {4{v[6]}};
            if (v[11:8] == 4'd9)       rq = "R3";
            else if (v[11:8] == 4'd7)  rq = "R8";
            else if (v[13:12] == 2'd3) rq = (v[11:8] == 4'd0) ? "R7" : "R4";
            else if (v[11:8] == 4'd0)  rq = "R9";
            else if (v[13:12] == 2'd2) rq = "R6";
            else                       rq = "R5";
            txn(p, v[11:8], 7'h00, 4'd3, 1'b1, v[13:12] != 2'd2, v[7]);
            expect_rsp(int'(v[5:3]), v[2:1], rq);
        end

        // R1: malformed tokens to endpoint 0 (would otherwise NAK)
        fifo_ready = 4'b0000;
        txn(T_IN, 4'd0, 7'h00, 4'd2, 1'b1, 1'b0, 1'b0); expect_rsp(0, 2'd0, "R1");
        txn(T_IN, 4'd0, 7'h00, 4'd3, 1'b0, 1'b0, 1'b0); expect_rsp(0, 2'd0, "R1");
        txn(8'h68, 4'd0, 7'h00, 4'd3, 1'b1, 1'b0, 1'b0); expect_rsp(0, 2'd0, "R1");
        txn(8'hD2, 4'd0, 7'h00, 4'd3, 1'b1, 1'b0, 1'b0); expect_rsp(0, 2'd0, "R1");

        // R2: address compare
        txn(T_IN, 4'd0, 7'h35, 4'd3, 1'b1, 1'b0, 1'b0); expect_rsp(0, 2'd0, "R2");
        dev_addr = 7'h35;
        txn(T_IN, 4'd0, 7'h35, 4'd3, 1'b1, 1'b0, 1'b0); expect_rsp(2, 2'd0, "R2");
        txn(T_IN, 4'd0, 7'h00, 4'd3, 1'b1, 1'b0, 1'b0); expect_rsp(0, 2'd0, "R2");
        dev_addr = 7'h00;

        // R3: duplicate number, lowest index wins; disabling it exposes the next
        ep_num[7:4] = 4'd0;
        txn(T_IN, 4'd0, 7'h00, 4'd3, 1'b1, 1'b0, 1'b0); expect_rsp(2, 2'd0, "R3");
        ep_en[0] = 1'b0;
        txn(T_IN, 4'd0, 7'h00, 4'd3, 1'b1, 1'b0, 1'b0); expect_rsp(3, 2'd1, "R3");
        ep_en[0] = 1'b1;
        ep_num[7:4] = 4'd2;

        // R10: exact timing of an IN response (endpoint number 2 -> STALL)
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = T_IN; tok_ep = 4'd2; tok_addr = 7'h00;
        @(negedge clk);
        tok_valid = 1'b0;
        check(hs_req && hs_pid == 8'h1E, "R10", "IN response cycle", hs_pid, 8'h1E);
        @(negedge clk);
        check(!hs_req && hs_pid == 8'h00, "R10", "IN pulse width", hs_req, 0);

        // R10: OUT timing (endpoint number 2 -> NAK)
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = T_OUT; tok_ep = 4'd2;
        @(negedge clk);
        tok_valid = 1'b0;
        check(!hs_req, "R10", "no handshake before data", hs_req, 0);
        data_done = 1'b1;
        @(negedge clk);
        data_done = 1'b0;
        check(hs_req && hs_pid == 8'h5A, "R10", "OUT handshake cycle", hs_pid, 8'h5A);
        @(negedge clk);
        check(!hs_req, "R10", "OUT pulse width", hs_req, 0);

        // R10: a token during the data wait cancels the handshake
        n_hs = 0; n_tx = 0;
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = T_OUT; tok_ep = 4'd0;
        @(negedge clk);
        tok_pid = T_IN; tok_ep = 4'd2;
        @(negedge clk);
        tok_valid = 1'b0; sample();
        data_done = 1'b1;
        @(negedge clk);
        data_done = 1'b0; sample();
        repeat (2) begin @(negedge clk); sample(); end
        check(n_hs == 0 && n_tx == 0, "R10", "cancelled wait", n_hs + n_tx, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule